// File: doc/BRIEF.md
# Multislope ADC Run-Up Sequencer

This block sequences the run-up phase of a multislope integrating converter. Every modulation cycle has the same length and the same shape. First comes a short slot that always applies the positive reference, then a short slot that always applies the negative reference. A long slot follows, and its polarity is chosen by the integrator comparator. Because every cycle switches the references at the same instants, the charge error from each transition is the same whatever the input signal is.

A start pulse opens an integration window. The window lasts a whole number of modulation cycles, chosen so that it fits inside one, two, four, eight or sixteen power-line periods. At the end of the window the block returns the switches to idle, so only the input stays connected. It then presents two counts: the number of cycles and the number of cycles whose long slot was positive. It also pulses a done strobe. Software or a follow-on block uses these counts together with a run-down measurement, which is not part of this block. Every switch-control output comes straight from a flip-flop, so each edge keeps a fixed relation to the system clock.

Top module: `runup_seq`

## Requirements
- R1: After an accepted start, the first modulation cycle begins in the next clock. Each cycle drives `sw_pos` for POS_CLKS clocks, then `sw_neg` for NEG_CLKS clocks, then the long slot for LONG_CLKS clocks. The long slot drives `sw_pos` or `sw_neg`, and the next cycle follows without a gap.
- R2: `comp` passes through a two-flop synchronizer. The synchronized value present at the last clock of the negative slot sets the polarity of the long slot that follows: 1 selects positive (`sw_pos`) and 0 selects negative (`sw_neg`).
- R3: Exactly one of `sw_pos`, `sw_neg` and `sw_idle` is high in every clock. `sw_idle` is high whenever no window is running.
- R4: `win_sel` is captured at start and gives the window multiple m: 0→1, 1→2, 2→4, 3→8, and 4 to 7→16. The window holds floor(PLC_CLKS·m / (POS_CLKS+NEG_CLKS+LONG_CLKS)) cycles.
- R5: At the end of a window, `cyc_count` equals the number of cycles in the window and `pos_count` equals the number of those cycles whose long slot was positive.
- R6: `done` is high for exactly one clock. That clock directly follows the final long-slot clock of the window, and in it `sw_idle` is high and the counts are valid.
- R7: `pos_count` and `cyc_count` keep their values after `done`, including while the next window runs, until that next window ends.
- R8: A start that arrives while a window is running has no effect on the sequence, the window length or the counts.
- R9: Reset, including reset in the middle of a window, drives `sw_idle` high, `done` low and both counts to zero.
- R10: A start presented in the same clock as `done` is accepted, and the next window begins in the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a window when the block is idle |
| win_sel | input | 3 | Window length select (power-line multiple) |
| comp | input | 1 | Asynchronous integrator comparator |
| sw_pos | output | 1 | Positive reference switch select |
| sw_neg | output | 1 | Negative reference switch select |
| sw_idle | output | 1 | Input-only (no reference) select |
| pos_count | output | CW | Cycles with a positive long slot in the last window |
| cyc_count | output | CW | Cycles in the last window |
| done | output | 1 | One-clock end-of-window strobe |

## Verification
The bench builds the block with POS_CLKS=2, NEG_CLKS=3, LONG_CLKS=5 and PLC_CLKS=47. With these values a cycle lasts 10 clocks and a window holds between 4 and 75 cycles. Because 47 is not a multiple of 10, every setting of the select exercises the round-down of R4. All eight select codes are swept against four comparator patterns: always low, always high, alternating, and every third cycle. The switch pattern is checked in every clock of every window. Back-to-back starts, a start during a window and a reset in the middle of a window are also checked.

// File: rtl/runup_seq.sv
module runup_seq #(
  parameter int POS_CLKS  = 125,
  parameter int NEG_CLKS  = 125,
  parameter int LONG_CLKS = 2500,
  parameter int PLC_CLKS  = 2500000,
  localparam int CYC_CLKS = POS_CLKS + NEG_CLKS + LONG_CLKS,
  localparam longint NMAX = (longint'(PLC_CLKS) * 16) / CYC_CLKS,
  localparam int CW = $clog2(NMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    win_sel,
  input  logic          comp,
  output logic          sw_pos,
  output logic          sw_neg,
  output logic          sw_idle,
  output logic [CW-1:0] pos_count,
  output logic [CW-1:0] cyc_count,
  output logic          done
);

  localparam int PMAX = (POS_CLKS > NEG_CLKS) ?
                        ((POS_CLKS > LONG_CLKS) ? POS_CLKS : LONG_CLKS) :
                        ((NEG_CLKS > LONG_CLKS) ? NEG_CLKS : LONG_CLKS);
  localparam int PW = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam longint N1  = longint'(PLC_CLKS) / CYC_CLKS;
  localparam longint N2  = (longint'(PLC_CLKS) * 2) / CYC_CLKS;
  localparam longint N4  = (longint'(PLC_CLKS) * 4) / CYC_CLKS;
  localparam longint N8  = (longint'(PLC_CLKS) * 8) / CYC_CLKS;
  localparam longint N16 = NMAX;

  typedef enum logic [1:0] {S_IDLE, S_POS, S_NEG, S_LONG} st_t;

  st_t           st, st_n;
  logic [PW-1:0] ph;
  logic [1:0]    sync;
  logic          pol;
  logic [CW-1:0] tgt, sel_tgt, cyc_acc, pos_acc;

  wire ph_last = (st == S_POS  && ph == PW'(POS_CLKS - 1)) ||
                 (st == S_NEG  && ph == PW'(NEG_CLKS - 1)) ||
                 (st == S_LONG && ph == PW'(LONG_CLKS - 1));
  wire go       = (st == S_IDLE) && start;
  wire cyc_end  = (st == S_LONG) && ph_last;
  wire win_end  = cyc_end && (cyc_acc + CW'(1) == tgt);
  wire long_pol = (st == S_NEG) ? sync[1] : pol;

  always_comb begin
    case (win_sel)
      3'd0:    sel_tgt = CW'(N1);
      3'd1:    sel_tgt = CW'(N2);
      3'd2:    sel_tgt = CW'(N4);
      3'd3:    sel_tgt = CW'(N8);
      default: sel_tgt = CW'(N16);
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (start)   st_n = S_POS;
      S_POS:  if (ph_last) st_n = S_NEG;
      S_NEG:  if (ph_last) st_n = S_LONG;
      S_LONG: if (ph_last) st_n = win_end ? S_IDLE : S_POS;
      default:             st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= '0;
      sync      <= '0;
      pol       <= 1'b0;
      tgt       <= '0;
      cyc_acc   <= '0;
      pos_acc   <= '0;
      pos_count <= '0;
      cyc_count <= '0;
      done      <= 1'b0;
      sw_pos    <= 1'b0;
      sw_neg    <= 1'b0;
      sw_idle   <= 1'b1;
    end else begin
      sync    <= {sync[0], comp};
      st      <= st_n;
      ph      <= (st_n != st || st_n == S_IDLE) ? '0 : ph + PW'(1);
      sw_pos  <= (st_n == S_POS) || (st_n == S_LONG && long_pol);
      sw_neg  <= (st_n == S_NEG) || (st_n == S_LONG && !long_pol);
      sw_idle <= (st_n == S_IDLE);
      done    <= win_end;
      if (st == S_NEG && ph_last) pol <= sync[1];
      if (go) begin
        tgt     <= sel_tgt;
        cyc_acc <= '0;
        pos_acc <= '0;
      end else if (cyc_end) begin
        cyc_acc <= cyc_acc + CW'(1);
        pos_acc <= pos_acc + CW'(pol);
      end
      if (win_end) begin
        cyc_count <= cyc_acc + CW'(1);
        pos_count <= pos_acc + CW'(pol);
      end
    end
  end

  a_r3_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sw_pos, sw_neg, sw_idle}));

  a_r1_neg_after_pos: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_pos) && !sw_idle) |-> sw_neg);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sw_idle);

  a_r5_pos_within_total: assert property (@(posedge clk) disable iff (!rst_n)
    pos_count <= cyc_count);

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(tgt));

  a_r7_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cyc_count) || $past(!rst_n));

endmodule

// File: tb/test_runup_seq.sv
module test_runup_seq;
  localparam int P = 2, N = 3, L = 5, PLC = 47, CYC = P + N + L;
  localparam int CW = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, comp = 1'b0;
  logic [2:0] win_sel = 3'd0;
  logic sw_pos, sw_neg, sw_idle, done;
  logic [CW-1:0] pos_count, cyc_count;

  int checks = 0, errors = 0;
  int prev_pos = 0, prev_cyc = 0;

  runup_seq #(.POS_CLKS(P), .NEG_CLKS(N), .LONG_CLKS(L), .PLC_CLKS(PLC)) i_runup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .win_sel(win_sel), .comp(comp),
    .sw_pos(sw_pos), .sw_neg(sw_neg), .sw_idle(sw_idle),
    .pos_count(pos_count), .cyc_count(cyc_count), .done(done));

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic pf(int p, int c);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return c[0];
      default: return (c % 3) == 0;
    endcase
  endfunction

  function automatic int exp_cycles(int sel);
    int m = (sel >= 4) ? 16 : (1 << sel);
    return (PLC * m) / CYC;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_window(int sel, int pat, bit started, bit chain);
    int n = exp_cycles(sel);
    int ep = 0;
    int bad = 0, bad_k = -1, bad_a = 0, bad_e = 0;
    for (int c = 0; c < n; c++) if (pf(pat, c)) ep++;
    if (!started) begin
      win_sel = 3'(sel);
      comp = pf(pat, 0);
      start = 1'b1;
    end
    @(posedge clk);
    for (int k = 0; k <= (chain ? 10 * n : 10 * n + 1); k++) begin
      @(negedge clk);
      if (k == 0) begin
        start = 1'b0;
        win_sel = 3'(7 - sel);
      end
      if (k == 23) start = 1'b1;
      if (k == 24) start = 1'b0;
      if (k < 10 * n) begin
        int r = k % CYC;
        logic [2:0] e;
        if (r < P) e = 3'b100;
        else if (r < P + N) e = 3'b010;
        else e = pf(pat, k / CYC) ? 3'b100 : 3'b010;
        if ({sw_pos, sw_neg, sw_idle} != e && bad == 0) begin
          bad = 1; bad_k = k; bad_a = int'({sw_pos, sw_neg, sw_idle}); bad_e = int'(e);
        end
        if (done) begin
          if (bad == 0) begin bad = 1; bad_k = k; bad_a = 1; bad_e = 0; end
        end
        if (k == 5) begin
          chk("R7 pos_count held into next window", int'(pos_count), prev_pos);
          chk("R7 cyc_count held into next window", int'(cyc_count), prev_cyc);
        end
        if (k > 0 && k % CYC == 0) comp = pf(pat, k / CYC);
      end else if (k == 10 * n) begin
        if (bad) begin
          errors++;
          $display("FAIL R1/R2/R8 sel=%0d pat=%0d clk %0d: actual %b expected %b",
                   sel, pat, bad_k, bad_a[2:0], bad_e[2:0]);
        end
        checks++;
        chk("R6 done at window end", int'(done), 1);
        chk("R3 idle at window end", int'({sw_pos, sw_neg, sw_idle}), 1);
        chk("R4 R5 cyc_count", int'(cyc_count), n);
        chk("R2 R5 pos_count", int'(pos_count), ep);
        prev_pos = ep; prev_cyc = n;
        if (chain) begin
          start = 1'b1;
          comp = pf(pat, 0);
          win_sel = 3'(sel);
        end
      end else begin
        chk("R6 done one clock", int'(done), 0);
        chk("R7 counts held after done", int'(cyc_count), n);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset idle", int'({sw_pos, sw_neg, sw_idle}), 1);
    chk("R9 reset done low", int'(done), 0);
    chk("R9 reset counts", int'(pos_count) + int'(cyc_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle with no window", int'(sw_idle), 1);

    for (int sel = 0; sel < 8; sel++)
      for (int pat = 0; pat < 4; pat++) begin
        run_window(sel, pat, 1'b0, 1'b0);
        @(negedge clk);
      end

    run_window(1, 2, 1'b0, 1'b1);
    run_window(1, 2, 1'b1, 1'b0);
    chk("R10 back-to-back window count", int'(cyc_count), exp_cycles(1));

    @(negedge clk);
    win_sel = 3'd2; comp = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 mid-window reset idle", int'({sw_pos, sw_neg, sw_idle}), 1);
    chk("R9 mid-window reset counts", int'(pos_count) + int'(cyc_count), 0);
    chk("R9 mid-window reset done", int'(done), 0);
    rst_n = 1'b1;
    prev_pos = 0; prev_cyc = 0;
    @(negedge clk);
    run_window(0, 3, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule